// File: doc/BRIEF.md
# Two-Slot Alternating Handshake Buffer

This block is a two-entry byte buffer placed between two four-phase push channels. The producer side is passive: a source presents a byte, raises a request, and the block acknowledges it. The consumer side is active: the block presents a byte, raises its own request, and waits for the sink to acknowledge. Both protocols follow return-to-zero signalling. The data must be valid before the request rises.

Storage is two byte registers, slot X and slot Y, whose roles alternate. After reset the block performs one lone input into slot X. From then on it repeats two steps. In the first step it emits slot X while it fills slot Y. In the second step it emits slot Y while it fills slot X. A step closes only when both of its handshakes have returned to zero. The handshakes are emulated in clocked logic. Data therefore never ripples from one register to the next. Each slot is written by the input channel and read by the output channel directly.

Top module: `wag_buffer`

## Requirements
- R1: While `rst_n` is low, and on the first cycles after it is released, `in_ack` and `out_req` are low.
- R2: The first byte accepted after reset is the first byte offered on the output. `out_req` stays low until that first input handshake has fully returned to zero.
- R3: Bytes leave on `out_data` in the order they were accepted on `in_data`. No byte is lost and no byte is duplicated, under any pattern of stalls on either side.
- R4: A byte is captured on the clock edge where `in_req` is seen high, and `in_ack` rises on that edge. The source may change `in_data` once it sees `in_ack` high, and this does not corrupt the stored byte.
- R5: `in_ack` falls only after `in_req` has been seen low. After it falls, no further input is acknowledged until the current step has closed.
- R6: `out_data` holds its value for at least one cycle before `out_req` rises. It stays unchanged for as long as `out_req` is high.
- R7: `out_req` rises only while `out_ack` is low. It falls only after `out_ack` has been seen high.
- R8: A step closes only when both its input and its output handshakes are complete. With the sink never acknowledging, exactly two bytes are accepted, a third request is left unacknowledged, and the first byte remains offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_req | input | 1 | Input channel request from source |
| in_ack | output | 1 | Input channel acknowledge |
| in_data | input | DATA_W | Input byte, valid while in_req is high |
| out_req | output | 1 | Output channel request to sink |
| out_ack | input | 1 | Output channel acknowledge from sink |
| out_data | output | DATA_W | Output byte, valid before and during out_req |

## Verification
The bench first blocks the sink completely. A design that let a step close on the input handshake alone would accept a third byte and overwrite slot X before it had been emitted. The bench then scrambles `in_data` as soon as `in_ack` is seen. A design that sampled the byte late, or let slot selection drift, would store the scrambled value, and the reference queue would report a wrong or out-of-order byte. Random stalls on both channels make either handshake finish first within each step. This exposes any mix-up of the X and Y roles. It also exposes an output request that rises before its data has settled or while the sink's acknowledge is still high.

// File: rtl/wag_pkg.sv
package wag_pkg;

  // Which slot is emitted in the current step; FILL is the lone first input.
  typedef enum logic [1:0] {
    PH_FILL  = 2'd0,
    PH_OUT_X = 2'd1,
    PH_OUT_Y = 2'd2
  } phase_t;

  typedef enum logic [1:0] {
    IN_IDLE = 2'd0,
    IN_HOLD = 2'd1,
    IN_DONE = 2'd2
  } in_st_t;

  typedef enum logic [1:0] {
    OUT_SETUP = 2'd0,
    OUT_REQ   = 2'd1,
    OUT_REL   = 2'd2,
    OUT_DONE  = 2'd3
  } out_st_t;

  function automatic phase_t phase_after(phase_t p);
    phase_t n;
    case (p)
      PH_OUT_X: n = PH_OUT_Y;
      default:  n = PH_OUT_X;
    endcase
    return n;
  endfunction

  // Slot X is the write target in every step except the one that emits X.
  function automatic logic fills_x(phase_t p);
    return p != PH_OUT_X;
  endfunction

endpackage

// File: rtl/wag_in_port.sv
module wag_in_port
  import wag_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic in_req,
  output logic in_ack,
  output logic capture,
  output logic done
);

  in_st_t st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IN_IDLE;
    end else if (restart) begin
      st <= IN_IDLE;
    end else begin
      case (st)
        IN_IDLE: if (in_req)  st <= IN_HOLD;
        IN_HOLD: if (!in_req) st <= IN_DONE;
        default: st <= st;
      endcase
    end
  end

  assign capture = (st == IN_IDLE) && in_req && !restart;
  assign in_ack  = (st == IN_HOLD);
  assign done    = (st == IN_DONE);

  // R4: acknowledge only answers a request seen high
  a_r4_ack_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ack) |-> $past(in_req));

  // R5: acknowledge is withdrawn only after the request has dropped
  a_r5_ack_drop_after_req_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ack) |-> !$past(in_req));

endmodule

// File: rtl/wag_out_port.sv
module wag_out_port
  import wag_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic out_ack,
  output logic out_req,
  output logic done
);

  out_st_t st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= OUT_DONE;
    end else if (restart) begin
      st <= OUT_SETUP;
    end else begin
      case (st)
        OUT_SETUP: st <= OUT_REQ;
        OUT_REQ:   if (out_ack)  st <= OUT_REL;
        OUT_REL:   if (!out_ack) st <= OUT_DONE;
        default:   st <= st;
      endcase
    end
  end

  assign out_req = (st == OUT_REQ);
  assign done    = (st == OUT_DONE);

  // R7: request rises only with acknowledge low, falls only after it was high
  a_r7_req_rise_ack_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_req) |-> !$past(out_ack));

  a_r7_req_fall_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_req) |-> $past(out_ack));

endmodule

// File: rtl/wag_slots.sv
module wag_slots #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_x,
  input  logic              cap_y,
  input  logic              emit_y,
  input  logic [DATA_W-1:0] in_data,
  output logic [DATA_W-1:0] out_data
);

  logic [DATA_W-1:0] slot_x;
  logic [DATA_W-1:0] slot_y;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_x <= '0;
      slot_y <= '0;
    end else begin
      if (cap_x) slot_x <= in_data;
      if (cap_y) slot_y <= in_data;
    end
  end

  assign out_data = emit_y ? slot_y : slot_x;

  // R8: at most one slot is written per cycle
  a_r8_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cap_x, cap_y}));

endmodule

// File: rtl/wag_buffer.sv
module wag_buffer
  import wag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_req,
  output logic              in_ack,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_req,
  input  logic              out_ack,
  output logic [DATA_W-1:0] out_data
);

  phase_t phase;
  logic   in_capture;
  logic   in_done;
  logic   out_done;
  logic   step_end;
  logic   cap_x;
  logic   cap_y;
  logic   emit_y;

  assign step_end = in_done && out_done;
  assign cap_x    = in_capture && fills_x(phase);
  assign cap_y    = in_capture && !fills_x(phase);
  assign emit_y   = (phase == PH_OUT_Y);

  always_ff @(posedge clk) begin
    if (!rst_n)        phase <= PH_FILL;
    else if (step_end) phase <= phase_after(phase);
  end

  wag_in_port i_in (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (step_end),
    .in_req  (in_req),
    .in_ack  (in_ack),
    .capture (in_capture),
    .done    (in_done)
  );

  wag_out_port i_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (step_end),
    .out_ack (out_ack),
    .out_req (out_req),
    .done    (out_done)
  );

  wag_slots #(.DATA_W(DATA_W)) i_slots (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_x    (cap_x),
    .cap_y    (cap_y),
    .emit_y   (emit_y),
    .in_data  (in_data),
    .out_data (out_data)
  );

  // R2: nothing is offered before the first input step has closed
  a_r2_no_output_in_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FILL) |-> !out_req);

  // R6: offered byte does not move while the request is up
  a_r6_out_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_req |-> $stable(out_data));

  // R8: a step cannot close while the input side is still mid-handshake
  a_r8_step_waits_input: assert property (@(posedge clk) disable iff (!rst_n)
    in_ack |=> $stable(phase));

endmodule

// File: tb/test_wag_buffer.sv
module test_wag_buffer;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_req;
  logic              in_ack;
  logic [DATA_W-1:0] in_data;
  logic              out_req;
  logic              out_ack;
  logic [DATA_W-1:0] out_data;

  int errors = 0;
  int checks = 0;
  int accepted = 0;
  int delivered = 0;
  bit cons_en = 1'b0;
  int prod_stall_max = 0;
  int cons_stall_max = 0;
  logic [DATA_W-1:0] send_q[$];
  logic [DATA_W-1:0] ref_q[$];
  logic [DATA_W-1:0] first_item;

  always #(CLK_PERIOD/2) clk = ~clk;

  wag_buffer #(.DATA_W(DATA_W)) i_wag_buffer (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_req   (in_req),
    .in_ack   (in_ack),
    .in_data  (in_data),
    .out_req  (out_req),
    .out_ack  (out_ack),
    .out_data (out_data)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Source: data first, request one cycle later, scramble data once acknowledged (R4)
  initial begin
    in_req  = 1'b0;
    in_data = '0;
    forever begin
      @(negedge clk);
      if (rst_n && send_q.size() != 0) begin
        logic [DATA_W-1:0] v;
        v = send_q.pop_front();
        in_data = v;
        @(negedge clk);
        in_req = 1'b1;
        do @(negedge clk); while (!in_ack);
        ref_q.push_back(v);
        accepted++;
        in_data = DATA_W'($urandom);
        in_req  = 1'b0;
        do @(negedge clk); while (in_ack);
        repeat ($urandom_range(prod_stall_max, 0)) @(negedge clk);
      end
    end
  end

  // Sink: compare with reference queue, hold off acknowledge at random
  initial begin
    out_ack = 1'b0;
    forever begin
      @(negedge clk);
      if (cons_en && out_req) begin
        logic [DATA_W-1:0] got;
        logic [DATA_W-1:0] exp_v;
        got   = out_data;
        exp_v = (ref_q.size() != 0) ? ref_q.pop_front() : ~got;
        check(got == exp_v, "R3", "output order", got, exp_v);
        repeat ($urandom_range(cons_stall_max, 0)) begin
          @(negedge clk);
          check(out_data == got && out_req, "R6", "data held under request", out_data, got);
        end
        out_ack = 1'b1;
        delivered++;
        do @(negedge clk); while (out_req);
        out_ack = 1'b0;
      end
    end
  end

  // Protocol monitor, sampled just after the falling edge
  initial begin
    logic p_in_ack, p_in_req, p_out_req, p_out_ack;
    logic [DATA_W-1:0] p_out_data;
    p_in_ack = 0; p_in_req = 0; p_out_req = 0; p_out_ack = 0; p_out_data = '0;
    forever begin
      @(negedge clk);
      #1;
      if (rst_n) begin
        if (in_ack && !p_in_ack)
          check(p_in_req, "R4", "in_ack rose without request", 0, 1);
        if (!in_ack && p_in_ack)
          check(!p_in_req, "R5", "in_ack fell with request high", 1, 0);
        if (out_req && !p_out_req) begin
          check(out_data == p_out_data, "R6", "data settled before request", out_data, p_out_data);
          check(!p_out_ack, "R7", "request rose with ack high", 1, 0);
        end
        if (!out_req && p_out_req)
          check(p_out_ack, "R7", "request fell without ack", 0, 1);
      end
      p_in_ack = in_ack; p_in_req = in_req; p_out_req = out_req;
      p_out_ack = out_ack; p_out_data = out_data;
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d delivered", delivered, accepted);
    finish_report();
  end

  initial begin
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    check(!in_ack, "R1", "in_ack in reset", in_ack, 0);
    check(!out_req, "R1", "out_req in reset", out_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!in_ack && !out_req, "R1", "handshakes idle after reset", {in_ack, out_req}, 0);

    // R2: no output before any input
    repeat (20) @(negedge clk);
    check(!out_req, "R2", "no request before first input", out_req, 0);

    // R8: sink blocked, source offers five bytes
    cons_en = 1'b0;
    first_item = 8'hA5;
    send_q.push_back(first_item);
    for (int i = 1; i < 5; i++) send_q.push_back(DATA_W'(8'h10 + i));
    repeat (100) @(negedge clk);
    check(accepted == 2, "R8", "bytes accepted while sink blocked", accepted, 2);
    check(!in_ack && in_req, "R8", "third request left pending", {in_ack, in_req}, 1);
    check(out_req, "R8", "first byte still offered", out_req, 1);
    check(out_data == first_item, "R2", "first byte offered first", out_data, first_item);

    // Release the sink and drain
    cons_en = 1'b1;
    while (delivered != 5) @(negedge clk);
    repeat (20) @(negedge clk);
    check(delivered == 5 && ref_q.size() == 0, "R3", "all stalled bytes delivered", delivered, 5);
    check(!out_req, "R5", "no request once drained", out_req, 0);

    // Random stalls on both sides
    prod_stall_max = 4;
    cons_stall_max = 4;
    for (int i = 0; i < 300; i++) send_q.push_back(DATA_W'($urandom));
    while (delivered != 305) @(negedge clk);

    // Source-heavy and sink-heavy mixes
    prod_stall_max = 0;
    cons_stall_max = 6;
    for (int i = 0; i < 60; i++) send_q.push_back(DATA_W'(i * 7));
    while (delivered != 365) @(negedge clk);
    prod_stall_max = 6;
    cons_stall_max = 0;
    for (int i = 0; i < 60; i++) send_q.push_back(DATA_W'(255 - i));
    while (delivered != 425) @(negedge clk);

    // Back-to-back, no stalls
    prod_stall_max = 0;
    for (int i = 0; i < 80; i++) send_q.push_back(DATA_W'($urandom));
    while (delivered != 505) @(negedge clk);
    repeat (20) @(negedge clk);
    check(accepted == 505, "R3", "total accepted", accepted, 505);
    check(delivered == accepted && ref_q.size() == 0, "R3", "no loss or duplicate",
          delivered, accepted);

    finish_report();
  end

endmodule